// File: doc/BRIEF.md
# Signed Comparator Built on Subtraction Flags

This block compares two two's-complement operands of a parameterised width (4 bits by default). It is purely combinational. It forms the difference X − Y on a ripple adder. Y is inverted bit by bit and the chain is seeded with a carry-in of one. From that difference it produces four condition flags: zero, negative, signed overflow and the unsigned carry-out.

The five signed relations (equal, less, less-or-equal, greater, greater-or-equal) are decoded only from the zero, negative and overflow flags. There is no separate magnitude-compare tree. A datapath that already holds a subtractor can therefore reuse it to resolve branch or select conditions. The raw difference and all flags are also exported for callers that want them directly.

Top module: `signed_sub_compare`

## Requirements
- R1: `diff` equals X − Y taken modulo 2^WIDTH for every operand pair.
- R2: `carry_out` is the carry out of the sign position of X + ~Y + 1, so it is 1 exactly when X ≥ Y read as unsigned numbers.
- R3: `flag_ovf` is 1 exactly when the carry into the sign position differs from the carry out of it. Equivalently, the operand signs (bit WIDTH−1) differ and the sign of `diff` differs from the sign of X.
- R4: `flag_zero` is 1 exactly when every bit of `diff` is 0, and `flag_neg` equals bit WIDTH−1 of `diff`.
- R5: `is_lt` equals `flag_neg` XOR `flag_ovf` and is 1 exactly when X < Y as signed values, including pairs whose true difference lies outside −2^(WIDTH−1) to 2^(WIDTH−1)−1.
- R6: `is_eq` equals `flag_zero` and is 1 exactly when X = Y.
- R7: `is_le` = `is_lt` OR `is_eq`, `is_gt` = NOT `is_le`, and `is_ge` = NOT `is_lt`, each matching the signed relation.
- R8: For every operand pair exactly one of `is_lt`, `is_eq` and `is_gt` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | WIDTH | Minuend, two's complement |
| op_y | input | WIDTH | Subtrahend, two's complement |
| diff | output | WIDTH | X − Y modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the sign position |
| flag_zero | output | 1 | Difference is zero |
| flag_neg | output | 1 | Sign bit of the difference |
| flag_ovf | output | 1 | Signed overflow of the subtraction |
| is_eq | output | 1 | X = Y |
| is_lt | output | 1 | X < Y, signed |
| is_le | output | 1 | X ≤ Y, signed |
| is_gt | output | 1 | X > Y, signed |
| is_ge | output | 1 | X ≥ Y, signed |

## Verification
The hardest pairs are those with opposite signs whose difference overflows, such as the most negative value minus a positive one. There a design that takes the relation from the negative flag alone reports the wrong order. The bench walks all pairs at the default width and holds each relation against a signed comparison. It also holds the overflow flag against the sign-agreement rule, so a design that wires overflow from the wrong carry pair fails on those pairs. Equal operands and the unsigned carry at the wrap points (0 − 1, maximum minus itself) catch a missing carry-in, which would leave every difference off by one and break equality.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
        logic carry;
    } sub_flags_t;

    typedef struct packed {
        logic eq;
        logic lt;
        logic le;
        logic gt;
        logic ge;
    } rel_t;

    function automatic rel_t decode_rel(input sub_flags_t f);
        rel_t r;
        logic less;
        less = f.neg ^ f.ovf;
        r.eq = f.zero;
        r.lt = less;
        r.le = f.zero | less;
        r.gt = ~(f.zero | less);
        r.ge = ~less;
        return r;
    endfunction

endpackage

// File: rtl/sub_ripple.sv
module sub_ripple #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             c_sign_in,
    output logic             c_out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] b_eff;

    assign chain[0] = sub;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        assign b_eff[i]    = b[i] ^ sub;
        assign sum[i]      = a[i] ^ b_eff[i] ^ chain[i];
        assign chain[i+1]  = (a[i] & b_eff[i]) | (a[i] & chain[i]) | (b_eff[i] & chain[i]);
    end

    assign c_sign_in = chain[MSB];
    assign c_out     = chain[WIDTH];

    always_comb begin
        if (sub) begin
            p_diff_mod_r1: assert (sum == WIDTH'(a - b))
                else $error("subtract result mismatch");
        end
    end
endmodule

// File: rtl/flag_unit.sv
module flag_unit
    import cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] d,
    input  logic             c_sign_in,
    input  logic             c_out,
    output sub_flags_t       flags
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        flags.zero  = ~|d;
        flags.neg   = d[MSB];
        flags.ovf   = c_sign_in ^ c_out;
        flags.carry = c_out;
    end

    always_comb begin
        p_ovf_sign_rule_r3: assert (flags.ovf == ((a[MSB] != b[MSB]) && (d[MSB] != a[MSB])))
            else $error("overflow flag disagrees with sign rule");
        p_carry_unsigned_r2: assert (flags.carry == (a >= b))
            else $error("carry does not reflect unsigned order");
    end
endmodule

// File: rtl/signed_sub_compare.sv
module signed_sub_compare
    import cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_x,
    input  logic [WIDTH-1:0] op_y,
    output logic [WIDTH-1:0] diff,
    output logic             carry_out,
    output logic             flag_zero,
    output logic             flag_neg,
    output logic             flag_ovf,
    output logic             is_eq,
    output logic             is_lt,
    output logic             is_le,
    output logic             is_gt,
    output logic             is_ge
);
    logic       c_in_sign;
    logic       c_last;
    sub_flags_t fl;
    rel_t       rel;

    sub_ripple #(.WIDTH(WIDTH)) u_sub (
        .a(op_x), .b(op_y), .sub(1'b1),
        .sum(diff), .c_sign_in(c_in_sign), .c_out(c_last)
    );

    flag_unit #(.WIDTH(WIDTH)) u_flags (
        .a(op_x), .b(op_y), .d(diff),
        .c_sign_in(c_in_sign), .c_out(c_last), .flags(fl)
    );

    assign rel = decode_rel(fl);

    assign carry_out = fl.carry;
    assign flag_zero = fl.zero;
    assign flag_neg  = fl.neg;
    assign flag_ovf  = fl.ovf;
    assign is_eq     = rel.eq;
    assign is_lt     = rel.lt;
    assign is_le     = rel.le;
    assign is_gt     = rel.gt;
    assign is_ge     = rel.ge;

    always_comb begin
        p_one_relation_r8: assert ($countones({is_lt, is_eq, is_gt}) == 1)
            else $error("relation outputs not one-hot");
        p_lt_signed_r5: assert (is_lt == ($signed(op_x) < $signed(op_y)))
            else $error("less-than disagrees with signed order");
        p_eq_operands_r6: assert (is_eq == (op_x == op_y))
            else $error("equal disagrees with operands");
    end
endmodule

// File: tb/sim_signed_sub_compare.sv
module sim_signed_sub_compare;
    localparam int W          = 4;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_x = '0;
    logic [W-1:0] op_y = '0;
    logic [W-1:0] diff;
    logic         carry_out, flag_zero, flag_neg, flag_ovf;
    logic         is_eq, is_lt, is_le, is_gt, is_ge;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    signed_sub_compare #(.WIDTH(W)) u0 (
        .op_x(op_x), .op_y(op_y), .diff(diff), .carry_out(carry_out),
        .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_ovf(flag_ovf),
        .is_eq(is_eq), .is_lt(is_lt), .is_le(is_le), .is_gt(is_gt), .is_ge(is_ge)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s x=%0d y=%0d: actual %0d expected %0d", req, op_x, op_y, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
        @(negedge clk);
        op_x = x;
        op_y = y;
        #1;
    endtask

    task automatic check_pair;
        logic [W-1:0] d;
        logic signed [W-1:0] sx, sy;
        logic lt, eq;
        d  = op_x - op_y;
        sx = op_x;
        sy = op_y;
        lt = sx < sy;
        eq = op_x == op_y;
        chk("R1 diff", diff, d);
        chk("R2 carry", carry_out, op_x >= op_y);
        chk("R3 ovf", flag_ovf, (op_x[W-1] != op_y[W-1]) && (d[W-1] != op_x[W-1]));
        chk("R4 zero", flag_zero, d == '0);
        chk("R4 neg", flag_neg, d[W-1]);
        chk("R5 lt", is_lt, lt);
        chk("R6 eq", is_eq, eq);
        chk("R7 le", is_le, lt | eq);
        chk("R7 gt", is_gt, !(lt | eq));
        chk("R7 ge", is_ge, !lt);
        chk("R8 onehot", is_lt + is_eq + is_gt, 1);
    endtask

    task automatic t_reset_state;
        apply('0, '0);
        chk("R6 eq at start", is_eq, 1);
        chk("R4 zero at start", flag_zero, 1);
        chk("R2 carry at start", carry_out, 1);
    endtask

    task automatic t_exhaustive;
        for (int i = 0; i < (1 << W); i++) begin
            for (int j = 0; j < (1 << W); j++) begin
                apply(W'(i), W'(j));
                check_pair();
            end
        end
    endtask

    task automatic t_overflow_corners;
        // most negative minus one: overflow flips N, R5 must still say less
        apply(4'b1000, 4'b0001);
        chk("R3 ovf min-1", flag_ovf, 1);
        chk("R5 lt min-1", is_lt, 1);
        chk("R4 neg min-1", flag_neg, 0);
        // max positive minus most negative: overflow, greater
        apply(4'b0111, 4'b1000);
        chk("R3 ovf max-min", flag_ovf, 1);
        chk("R7 gt max-min", is_gt, 1);
        // 0 - 1 : no carry, negative, less
        apply(4'b0000, 4'b0001);
        chk("R2 carry 0-1", carry_out, 0);
        chk("R5 lt 0-1", is_lt, 1);
        // equal extremes
        apply(4'b1111, 4'b1111);
        chk("R6 eq max", is_eq, 1);
        chk("R2 carry eq", carry_out, 1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_overflow_corners();
        t_exhaustive();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule